// File: doc/BRIEF.md
# SPI FIFO Word Packer

This block sits between a 32-bit host FIFO interface and a serial shift engine that moves words of 4 to 32 bits. On the transmit path, the host pushes 32-bit entries. The shift engine pulls SPI words out of them one at a time. On the receive path, the shift engine delivers SPI words. The block collects them into 32-bit entries that the host then pops. How densely words are packed into an entry depends on whether the word size divides 32 exactly.

The host sees the receive side through a small status view. This view gives the entry count, a flag that marks the newest entry as the end of a receive command, and the number of meaningful bytes in that closing entry. A short final entry is therefore reported rather than padded silently.

Interrupt-style levels and pulses report the following:
- a transmit level at or below a programmable mark;
- a receive level at or above a programmable mark;
- the completion of a receive command.

A flow-control output tells the far end whether there is room to receive. Overflow and underflow on either FIFO set sticky error bits that stay set until reset. Configuration (word size and bit order) is held stable while a transfer is in flight.

Top module: `spi_word_packer`

## Requirements
- R1: After reset both FIFOs are empty: txLevel = 0, rxCount = 0, txWordValid = 0, rxLastFlag = 0, rxLastBytes = 0, rxDoneIrq = 0, rxRoom = 1, and all four error bits are 0.
- R2: For a word size of 4, 8, 16 or 32 bits, one FIFO entry holds 32/size words, with lane k at entry bits [k*size +: size]. For any other size from 4 to 32, an entry holds one word in bits [size-1:0].
- R3: The transmit path presents lanes from lane 0 upward as txWordData, right-aligned. Each txWordReady while txWordValid is high advances one lane. The entry is removed after its last lane.
- R4: The receive path places incoming words into lanes from lane 0 upward. It writes the entry when every lane is filled or when rxWordLast accompanies the word. Unused upper bits are zero.
- R5: With cfgLsbFirst = 1, the low size bits of every word are bit-reversed on both paths. A shift engine that always shifts from bit size-1 therefore sends or receives the least significant bit first.
- R6: rxLastFlag is 1 when the newest receive entry was closed by rxWordLast. rxLastBytes then gives the bytes it occupies: ceil(filled lanes*size/8) when packed. Otherwise it gives ceil(size/8) rounded up to a power of two (1, 2 or 4); a value of 4 means a full entry. Both read 0 when the flag is 0.
- R7: txWmIrq is high exactly when txWatermark is nonzero and txLevel <= txWatermark.
- R8: rxDoneIrq is a one-cycle pulse, one cycle after the entry closed by rxWordLast is written.
- R9: rxRoom is high exactly when rxCount < FIFO_DEPTH-2.
- R10: rxWmIrq is high exactly when rxWatermark is nonzero and rxCount >= rxWatermark.
- R11: Each error bit is sticky until reset, and the offending data is dropped:
  - txOvfErr is set by a write to a full transmit FIFO.
  - txUdfErr is set by txWordReady with no word available.
  - rxOvfErr is set by an entry write to a full receive FIFO.
  - rxUdfErr is set by rxRdEn on an empty receive FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWordBits | input | 6 | SPI word size in bits, 4 to 32 |
| cfgLsbFirst | input | 1 | 1 = least significant bit first |
| txWatermark | input | CNT_W | Transmit mark, 0 disables |
| rxWatermark | input | CNT_W | Receive mark, 0 disables |
| txWrEn | input | 1 | Host pushes a transmit entry |
| txWrData | input | 32 | Transmit entry |
| txWordReady | input | 1 | Shift engine takes the current word |
| txWordValid | output | 1 | A transmit word is available |
| txWordData | output | 32 | Current transmit word, right-aligned |
| txLevel | output | CNT_W | Transmit FIFO entry count |
| rxWordValid | input | 1 | Shift engine delivers a word |
| rxWordData | input | 32 | Received word, right-aligned |
| rxWordLast | input | 1 | Word is the last of a receive command |
| rxRdEn | input | 1 | Host pops the oldest receive entry |
| rxRdData | output | 32 | Oldest receive entry |
| rxCount | output | CNT_W | Receive FIFO entry count |
| rxLastFlag | output | 1 | Newest entry closes a command |
| rxLastBytes | output | 3 | Bytes occupied in that closing entry |
| rxRoom | output | 1 | Room to keep receiving |
| txWmIrq | output | 1 | Transmit level at or below mark |
| rxWmIrq | output | 1 | Receive level at or above mark |
| rxDoneIrq | output | 1 | Receive command completed (pulse) |
| txOvfErr | output | 1 | Sticky transmit overflow |
| txUdfErr | output | 1 | Sticky transmit underflow |
| rxOvfErr | output | 1 | Sticky receive overflow |
| rxUdfErr | output | 1 | Sticky receive underflow |

## Verification
Several properties are watched on every cycle:
- A partly consumed transmit entry is never lost from the FIFO.
- Written entries land as the newest FIFO entry.
- FIFO counts stay bounded.
- Error bits never clear.
- The room output drops at the threshold.
- A completion pulse always has a closed entry behind it.

Lane order, bit reversal, the padding of a short closing entry, byte counts and mark levels depend on the data and configuration. These can only be shown by the bench's directed and seeded random transfers, compared against a model of the packing rules.

// File: rtl/spi_pack_pkg.sv
package spi_pack_pkg;
  localparam int PK_DATA_W    = 32;
  localparam int PK_MIN_BITS  = 4;
  localparam int PK_MAX_LANES = PK_DATA_W / PK_MIN_BITS;
  localparam int PK_SLOT_W    = $clog2(PK_MAX_LANES);
  localparam int PK_BITS_W    = $clog2(PK_DATA_W + 1);
  localparam int PK_BYTES_W   = $clog2(PK_DATA_W / 8 + 1);
  localparam int PK_RXE_W     = PK_DATA_W + 1 + PK_BYTES_W;

  typedef logic [PK_DATA_W-1:0] pkWord_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic                  txPop;
    logic                  rxTake;
    logic                  rxPush;
    logic                  rxLast;
    logic [PK_BYTES_W-1:0] rxBytes;
    logic [PK_SLOT_W-1:0]  txSlot;
    logic [PK_SLOT_W-1:0]  rxSlot;
  } pkStrobes_t;

  function automatic pkWord_t wordMask(input logic [PK_BITS_W-1:0] bits);
    pkWord_t m;
    for (int i = 0; i < PK_DATA_W; i++) m[i] = (i < int'(bits));
    return m;
  endfunction

  // Reverse the low 'bits' bits of v; upper bits cleared.
  function automatic pkWord_t revLow(input pkWord_t v, input logic [PK_BITS_W-1:0] bits);
    pkWord_t r;
    r = '0;
    for (int i = 0; i < PK_DATA_W; i++) begin
      for (int j = 0; j < PK_DATA_W; j++) begin
        if ((i < int'(bits)) && (i + j == int'(bits) - 1)) r[i] = v[j];
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/spi_pack_fifo.sv
module spi_pack_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  output logic [WIDTH-1:0] newestData,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr, prevPtr;
  logic doWr, doRd;

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
  assign doWr  = wrEn && !full;
  assign doRd  = rdEn && !empty;
  assign prevPtr = (wrPtr == '0) ? PTR_LAST : wrPtr - 1'b1;
  assign rdData     = mem[rdPtr];
  assign newestData = mem[prevPtr];

  always_ff @(posedge clk) begin
    if (doWr) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doWr) wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
      if (doRd) rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
      case ({doWr, doRd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  a_r11_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
endmodule

// File: rtl/spi_pack_dpath.sv
module spi_pack_dpath import spi_pack_pkg::*; #(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [PK_BITS_W-1:0]  cfgBits,
  input  logic                  cfgLsbFirst,
  input  pkStrobes_t            strobes,
  input  logic                  txWrEn,
  input  pkWord_t               txWrData,
  output pkWord_t               txWordData,
  input  pkWord_t               rxWordData,
  input  logic                  rxRdEn,
  output pkWord_t               rxRdData,
  output logic                  rxLastFlag,
  output logic [PK_BYTES_W-1:0] rxLastBytes,
  output logic [CNT_W-1:0]      txCount,
  output logic [CNT_W-1:0]      rxCount,
  output logic                  txFull,
  output logic                  txEmpty,
  output logic                  rxFull,
  output logic                  rxEmpty
);
  localparam int SHIFT_W = PK_SLOT_W + PK_BITS_W;

  pkWord_t mask, txHead, txNewest, txLane;
  pkWord_t rxIn, rxPlaced, rxMerged, rxAsm;
  logic [SHIFT_W-1:0] txShift, rxShift;
  logic [PK_RXE_W-1:0] rxEntryIn, rxHead, rxNewest;

  assign mask = wordMask(cfgBits);

  spi_pack_fifo #(.WIDTH(PK_DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) txFifo (
    .clk(clk), .rstN(rstN), .wrEn(txWrEn), .wrData(txWrData), .rdEn(strobes.txPop),
    .rdData(txHead), .newestData(txNewest), .count(txCount), .full(txFull), .empty(txEmpty)
  );

  // Transmit: pick the lane and fix bit order.
  assign txShift = SHIFT_W'(strobes.txSlot) * SHIFT_W'(cfgBits);
  assign txLane  = (txHead >> txShift) & mask;
  assign txWordData = cfgLsbFirst ? revLow(txLane, cfgBits) : txLane;

  // Receive: fix bit order, place in its lane, merge with partial entry.
  assign rxIn     = (cfgLsbFirst ? revLow(rxWordData, cfgBits) : rxWordData) & mask;
  assign rxShift  = SHIFT_W'(strobes.rxSlot) * SHIFT_W'(cfgBits);
  assign rxPlaced = rxIn << rxShift;
  assign rxMerged = rxAsm | rxPlaced;
  assign rxEntryIn = {strobes.rxLast, strobes.rxBytes, rxMerged};

  always_ff @(posedge clk) begin
    if (!rstN)               rxAsm <= '0;
    else if (strobes.rxPush) rxAsm <= '0;
    else if (strobes.rxTake) rxAsm <= rxMerged;
  end

  spi_pack_fifo #(.WIDTH(PK_RXE_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) rxFifo (
    .clk(clk), .rstN(rstN), .wrEn(strobes.rxPush), .wrData(rxEntryIn), .rdEn(rxRdEn),
    .rdData(rxHead), .newestData(rxNewest), .count(rxCount), .full(rxFull), .empty(rxEmpty)
  );

  assign rxRdData    = rxHead[PK_DATA_W-1:0];
  assign rxLastFlag  = !rxEmpty && rxNewest[PK_RXE_W-1];
  assign rxLastBytes = rxLastFlag ? rxNewest[PK_DATA_W +: PK_BYTES_W] : '0;

  // R3: an accepted host write becomes the newest transmit entry.
  a_r3_tx_store: assert property (@(posedge clk) disable iff (!rstN)
    (txWrEn && !txFull) |=> (txNewest == $past(txWrData)));
endmodule

// File: rtl/spi_pack_ctrl.sv
module spi_pack_ctrl import spi_pack_pkg::*; #(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PK_BITS_W-1:0] cfgBits,
  input  logic [CNT_W-1:0]     txWatermark,
  input  logic [CNT_W-1:0]     rxWatermark,
  input  logic                 txWrEn,
  input  logic                 txWordReady,
  input  logic                 rxWordValid,
  input  logic                 rxWordLast,
  input  logic                 rxRdEn,
  input  logic                 txFull,
  input  logic                 txEmpty,
  input  logic                 rxFull,
  input  logic                 rxEmpty,
  input  logic [CNT_W-1:0]     txCount,
  input  logic [CNT_W-1:0]     rxCount,
  output pkStrobes_t           strobes,
  output logic                 txWordValid,
  output logic                 txWmIrq,
  output logic                 rxWmIrq,
  output logic                 rxRoom,
  output logic                 rxDoneIrq,
  output logic                 txOvfErr,
  output logic                 txUdfErr,
  output logic                 rxOvfErr,
  output logic                 rxUdfErr
);
  localparam int LW = PK_SLOT_W + 1;
  localparam logic [CNT_W-1:0] ROOM_LIMIT = CNT_W'(DEPTH - 2);

  logic [LW-1:0] lanes;
  logic isPacked;
  logic [PK_BYTES_W-1:0] entryBytes, packedBytes;
  logic [PK_SLOT_W-1:0] lastSlot, txSlot, rxSlot;
  logic [9:0] bitSum;
  logic txTake, txEnd, rxEnd, rxPush;

  // Packing density from word size.
  always_comb begin
    isPacked = 1'b1;
    unique case (cfgBits)
      PK_BITS_W'(4):  lanes = LW'(8);
      PK_BITS_W'(8):  lanes = LW'(4);
      PK_BITS_W'(16): lanes = LW'(2);
      PK_BITS_W'(32): lanes = LW'(1);
      default: begin
        lanes    = LW'(1);
        isPacked = 1'b0;
      end
    endcase
    if (cfgBits <= PK_BITS_W'(8))       entryBytes = PK_BYTES_W'(1);
    else if (cfgBits <= PK_BITS_W'(16)) entryBytes = PK_BYTES_W'(2);
    else                                entryBytes = PK_BYTES_W'(4);
  end

  assign lastSlot    = PK_SLOT_W'(lanes - 1'b1);
  assign bitSum      = (10'(rxSlot) + 10'd1) * 10'(cfgBits) + 10'd7;
  assign packedBytes = PK_BYTES_W'(bitSum >> 3);

  assign txWordValid = !txEmpty;
  assign txTake = txWordReady && !txEmpty;
  assign txEnd  = (txSlot == lastSlot);
  assign rxEnd  = (rxSlot == lastSlot) || rxWordLast;
  assign rxPush = rxWordValid && rxEnd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txSlot <= '0;
      rxSlot <= '0;
    end else begin
      if (txTake)      txSlot <= txEnd ? '0 : txSlot + 1'b1;
      if (rxWordValid) rxSlot <= rxEnd ? '0 : rxSlot + 1'b1;
    end
  end

  always_comb begin
    strobes.txPop   = txTake && txEnd;
    strobes.rxTake  = rxWordValid;
    strobes.rxPush  = rxPush;
    strobes.rxLast  = rxWordLast;
    strobes.rxBytes = isPacked ? packedBytes : entryBytes;
    strobes.txSlot  = txSlot;
    strobes.rxSlot  = rxSlot;
  end

  assign txWmIrq = (txWatermark != '0) && (txCount <= txWatermark);
  assign rxWmIrq = (rxWatermark != '0) && (rxCount >= rxWatermark);
  assign rxRoom  = (rxCount < ROOM_LIMIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxDoneIrq <= 1'b0;
      txOvfErr  <= 1'b0;
      txUdfErr  <= 1'b0;
      rxOvfErr  <= 1'b0;
      rxUdfErr  <= 1'b0;
    end else begin
      rxDoneIrq <= rxPush && rxWordLast && !rxFull;
      if (txWrEn && txFull)       txOvfErr <= 1'b1;
      if (txWordReady && txEmpty) txUdfErr <= 1'b1;
      if (rxPush && rxFull)       rxOvfErr <= 1'b1;
      if (rxRdEn && rxEmpty)      rxUdfErr <= 1'b1;
    end
  end

  // R3: a partly consumed entry is still held in the transmit FIFO.
  a_r3_slot_needs_entry: assert property (@(posedge clk) disable iff (!rstN)
    (txSlot != '0) |-> !txEmpty);
  // R11: error bits never clear.
  a_r11_tx_udf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    txUdfErr |=> txUdfErr);
  a_r11_rx_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    rxOvfErr |=> rxOvfErr);
  // R9: no room at or above the threshold.
  a_r9_room_limit: assert property (@(posedge clk) disable iff (!rstN)
    (rxCount >= ROOM_LIMIT) |-> !rxRoom);
  // R7: a zero mark keeps the transmit interrupt quiet.
  a_r7_wm_zero_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (txWatermark == '0) |-> !txWmIrq);
endmodule

// File: rtl/spi_word_packer.sv
module spi_word_packer import spi_pack_pkg::*; #(
  parameter int FIFO_DEPTH = 8,
  parameter int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [5:0]       cfgWordBits,
  input  logic             cfgLsbFirst,
  input  logic [CNT_W-1:0] txWatermark,
  input  logic [CNT_W-1:0] rxWatermark,
  input  logic             txWrEn,
  input  logic [31:0]      txWrData,
  input  logic             txWordReady,
  output logic             txWordValid,
  output logic [31:0]      txWordData,
  output logic [CNT_W-1:0] txLevel,
  input  logic             rxWordValid,
  input  logic [31:0]      rxWordData,
  input  logic             rxWordLast,
  input  logic             rxRdEn,
  output logic [31:0]      rxRdData,
  output logic [CNT_W-1:0] rxCount,
  output logic             rxLastFlag,
  output logic [2:0]       rxLastBytes,
  output logic             rxRoom,
  output logic             txWmIrq,
  output logic             rxWmIrq,
  output logic             rxDoneIrq,
  output logic             txOvfErr,
  output logic             txUdfErr,
  output logic             rxOvfErr,
  output logic             rxUdfErr
);
  pkStrobes_t strobes;
  logic txFull, txEmpty, rxFull, rxEmpty;

  spi_pack_ctrl #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) ctrl (
    .clk(clk), .rstN(rstN), .cfgBits(cfgWordBits),
    .txWatermark(txWatermark), .rxWatermark(rxWatermark),
    .txWrEn(txWrEn), .txWordReady(txWordReady), .rxWordValid(rxWordValid),
    .rxWordLast(rxWordLast), .rxRdEn(rxRdEn),
    .txFull(txFull), .txEmpty(txEmpty), .rxFull(rxFull), .rxEmpty(rxEmpty),
    .txCount(txLevel), .rxCount(rxCount), .strobes(strobes),
    .txWordValid(txWordValid), .txWmIrq(txWmIrq), .rxWmIrq(rxWmIrq),
    .rxRoom(rxRoom), .rxDoneIrq(rxDoneIrq),
    .txOvfErr(txOvfErr), .txUdfErr(txUdfErr), .rxOvfErr(rxOvfErr), .rxUdfErr(rxUdfErr)
  );

  spi_pack_dpath #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) dpath (
    .clk(clk), .rstN(rstN), .cfgBits(cfgWordBits), .cfgLsbFirst(cfgLsbFirst),
    .strobes(strobes), .txWrEn(txWrEn), .txWrData(txWrData), .txWordData(txWordData),
    .rxWordData(rxWordData), .rxRdEn(rxRdEn), .rxRdData(rxRdData),
    .rxLastFlag(rxLastFlag), .rxLastBytes(rxLastBytes),
    .txCount(txLevel), .rxCount(rxCount),
    .txFull(txFull), .txEmpty(txEmpty), .rxFull(rxFull), .rxEmpty(rxEmpty)
  );

  // R8: a completion pulse always has a closed entry behind it.
  a_r8_done_has_entry: assert property (@(posedge clk) disable iff (!rstN)
    rxDoneIrq |-> (rxCount != '0) && rxLastFlag);
endmodule

// File: tb/spi_word_packer_test.sv
module spi_word_packer_test;
  localparam int DEPTH = 8;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [5:0] cfgWordBits = 6'd8;
  logic cfgLsbFirst = 1'b0;
  logic [CW-1:0] txWatermark = '0, rxWatermark = '0;
  logic txWrEn = 1'b0, txWordReady = 1'b0, rxWordValid = 1'b0, rxWordLast = 1'b0, rxRdEn = 1'b0;
  logic [31:0] txWrData = '0, rxWordData = '0;
  logic txWordValid, rxLastFlag, rxRoom, txWmIrq, rxWmIrq, rxDoneIrq;
  logic txOvfErr, txUdfErr, rxOvfErr, rxUdfErr;
  logic [31:0] txWordData, rxRdData;
  logic [CW-1:0] txLevel, rxCount;
  logic [2:0] rxLastBytes;

  int nChk = 0, nBad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_word_packer #(.FIFO_DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .cfgWordBits(cfgWordBits), .cfgLsbFirst(cfgLsbFirst),
    .txWatermark(txWatermark), .rxWatermark(rxWatermark),
    .txWrEn(txWrEn), .txWrData(txWrData), .txWordReady(txWordReady),
    .txWordValid(txWordValid), .txWordData(txWordData), .txLevel(txLevel),
    .rxWordValid(rxWordValid), .rxWordData(rxWordData), .rxWordLast(rxWordLast),
    .rxRdEn(rxRdEn), .rxRdData(rxRdData), .rxCount(rxCount), .rxLastFlag(rxLastFlag),
    .rxLastBytes(rxLastBytes), .rxRoom(rxRoom), .txWmIrq(txWmIrq), .rxWmIrq(rxWmIrq),
    .rxDoneIrq(rxDoneIrq), .txOvfErr(txOvfErr), .txUdfErr(txUdfErr),
    .rxOvfErr(rxOvfErr), .rxUdfErr(rxUdfErr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  function automatic int mLanes(input int bits);
    return (32 % bits == 0) ? 32 / bits : 1;
  endfunction

  function automatic logic [31:0] mMask(input int bits);
    return (bits == 32) ? 32'hFFFF_FFFF : ((32'd1 << bits) - 32'd1);
  endfunction

  function automatic logic [31:0] mRev(input logic [31:0] v, input int bits);
    logic [31:0] r = '0;
    for (int i = 0; i < bits; i++) r[i] = v[bits - 1 - i];
    return r;
  endfunction

  function automatic int mBytes(input int bits, input int filled);
    if (32 % bits == 0) return (filled * bits + 7) / 8;
    if (bits <= 8) return 1;
    if (bits <= 16) return 2;
    return 4;
  endfunction

  function automatic logic [31:0] mTxWord(input logic [31:0] ent, input int bits, input int lane, input bit lsb);
    logic [31:0] w;
    w = (ent >> (lane * bits)) & mMask(bits);
    return lsb ? mRev(w, bits) : w;
  endfunction

  task automatic setCfg(input int bits, input bit lsb);
    cfgWordBits = 6'(bits);
    cfgLsbFirst = lsb;
  endtask

  // Starts and ends at a negedge.
  task automatic runTx(input int bits, input bit lsb, input int n, input logic [31:0] fixed, input bit useFixed);
    logic [31:0] ent [DEPTH];
    int lanes = mLanes(bits);
    setCfg(bits, lsb);
    for (int i = 0; i < n; i++) begin
      ent[i] = useFixed ? fixed : $urandom;
      txWrEn = 1'b1;
      txWrData = ent[i];
      @(negedge clk);
    end
    txWrEn = 1'b0;
    eq("R3 tx level after writes", 32'(txLevel), 32'(n));
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < lanes; k++) begin
        eq("R3 tx word valid", 32'(txWordValid), 32'd1);
        eq(lsb ? "R5 R2 tx word lsb-first" : "R2 tx word lane", txWordData, mTxWord(ent[i], bits, k, lsb));
        txWordReady = 1'b1;
        @(negedge clk);
      end
    end
    txWordReady = 1'b0;
    eq("R3 tx drained", 32'(txWordValid), 32'd0);
  endtask

  task automatic runRx(input int bits, input bit lsb, input int nWords);
    logic [31:0] expE [DEPTH];
    logic [31:0] acc = '0;
    logic [31:0] w;
    int lanes = mLanes(bits);
    int slot = 0, ne = 0, filled = 0;
    setCfg(bits, lsb);
    for (int i = 0; i < nWords; i++) begin
      w = $urandom;
      acc |= ((lsb ? mRev(w, bits) : w) & mMask(bits)) << (slot * bits);
      if (slot == lanes - 1 || i == nWords - 1) begin
        filled = slot + 1;
        expE[ne] = acc;
        ne++;
        acc = '0;
        slot = 0;
      end else slot++;
      rxWordValid = 1'b1;
      rxWordData = w;
      rxWordLast = (i == nWords - 1);
      @(negedge clk);
    end
    rxWordValid = 1'b0;
    rxWordLast = 1'b0;
    eq("R8 done pulse high", 32'(rxDoneIrq), 32'd1);
    eq("R4 rx count", 32'(rxCount), 32'(ne));
    eq("R6 rx last flag", 32'(rxLastFlag), 32'd1);
    eq("R6 rx last bytes", 32'(rxLastBytes), 32'(mBytes(bits, filled)));
    @(negedge clk);
    eq("R8 done pulse single", 32'(rxDoneIrq), 32'd0);
    for (int i = 0; i < ne; i++) begin
      eq(lsb ? "R5 R4 rx entry lsb-first" : "R4 rx entry", rxRdData, expE[i]);
      rxRdEn = 1'b1;
      @(negedge clk);
    end
    rxRdEn = 1'b0;
    eq("R4 rx drained", 32'(rxCount), 32'd0);
    eq("R6 flag clear when empty", 32'(rxLastFlag), 32'd0);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    eq("R1 txLevel", 32'(txLevel), 0);
    eq("R1 rxCount", 32'(rxCount), 0);
    eq("R1 txWordValid", 32'(txWordValid), 0);
    eq("R1 rxLastFlag", 32'(rxLastFlag), 0);
    eq("R1 rxLastBytes", 32'(rxLastBytes), 0);
    eq("R1 rxDoneIrq", 32'(rxDoneIrq), 0);
    eq("R1 rxRoom", 32'(rxRoom), 1);
    eq("R1 errors", {28'd0, txOvfErr, txUdfErr, rxOvfErr, rxUdfErr}, 0);

    // R2 directed lane layouts
    runTx(8, 1'b0, 1, 32'h4433_2211, 1'b1);
    runTx(12, 1'b0, 1, 32'hABCD_E123, 1'b1);
    runTx(4, 1'b1, 1, 32'h8765_432A, 1'b1);
    // R6 short closing entries
    runRx(8, 1'b0, 3);
    runRx(4, 1'b0, 3);
    runRx(12, 1'b0, 1);
    runRx(20, 1'b1, 2);
    runRx(6, 1'b0, 1);
    runRx(16, 1'b1, 4);

    // R7 transmit mark
    setCfg(32, 1'b0);
    txWatermark = CW'(2);
    @(negedge clk);
    eq("R7 irq at empty level", 32'(txWmIrq), 1);
    for (int i = 0; i < 3; i++) begin
      txWrEn = 1'b1;
      txWrData = 32'(i);
      @(negedge clk);
    end
    txWrEn = 1'b0;
    eq("R7 irq off above mark", 32'(txWmIrq), 0);
    txWordReady = 1'b1;
    @(negedge clk);
    txWordReady = 1'b0;
    eq("R7 irq at mark", 32'(txWmIrq), 1);
    txWatermark = '0;
    @(negedge clk);
    eq("R7 zero mark disables", 32'(txWmIrq), 0);
    txWordReady = 1'b1;
    repeat (2) @(negedge clk);
    txWordReady = 1'b0;
    eq("R7 drained", 32'(txLevel), 0);

    // R9 R10 R11 receive fill and overflow
    begin
      logic [31:0] words [DEPTH];
      setCfg(32, 1'b0);
      rxWatermark = CW'(2);
      for (int i = 0; i <= DEPTH; i++) begin
        if (i < DEPTH) words[i] = $urandom;
        rxWordValid = 1'b1;
        rxWordData = (i < DEPTH) ? words[i] : 32'hDEAD_BEEF;
        @(negedge clk);
        rxWordValid = 1'b0;
        if (i == 0) eq("R10 rx mark below", 32'(rxWmIrq), 0);
        if (i == 1) eq("R10 rx mark reached", 32'(rxWmIrq), 1);
        if (i == DEPTH - 4) eq("R9 room below limit", 32'(rxRoom), 1);
        if (i == DEPTH - 3) eq("R9 no room at limit", 32'(rxRoom), 0);
        if (i == DEPTH - 1) eq("R11 no rx overflow yet", 32'(rxOvfErr), 0);
      end
      eq("R11 rx overflow set", 32'(rxOvfErr), 1);
      eq("R11 rx count full", 32'(rxCount), DEPTH);
      eq("R6 no last flag without last", 32'(rxLastFlag), 0);
      for (int i = 0; i < DEPTH; i++) begin
        eq("R11 rx kept data", rxRdData, words[i]);
        rxRdEn = 1'b1;
        @(negedge clk);
      end
      eq("R11 no rx underflow yet", 32'(rxUdfErr), 0);
      @(negedge clk);
      rxRdEn = 1'b0;
      eq("R11 rx underflow set", 32'(rxUdfErr), 1);
      rxWatermark = '0;
    end

    // R11 transmit overflow and underflow
    begin
      logic [31:0] ents [DEPTH];
      setCfg(32, 1'b0);
      for (int i = 0; i <= DEPTH; i++) begin
        if (i < DEPTH) ents[i] = $urandom;
        txWrEn = 1'b1;
        txWrData = (i < DEPTH) ? ents[i] : 32'hBAD0_0BAD;
        @(negedge clk);
      end
      txWrEn = 1'b0;
      eq("R11 tx overflow set", 32'(txOvfErr), 1);
      eq("R11 tx level full", 32'(txLevel), DEPTH);
      for (int i = 0; i < DEPTH; i++) begin
        eq("R11 tx kept data", txWordData, ents[i]);
        txWordReady = 1'b1;
        @(negedge clk);
      end
      eq("R11 no tx underflow yet", 32'(txUdfErr), 0);
      @(negedge clk);
      txWordReady = 1'b0;
      eq("R11 tx underflow set", 32'(txUdfErr), 1);
      repeat (3) @(negedge clk);
      eq("R11 errors stay", {28'd0, txOvfErr, txUdfErr, rxOvfErr, rxUdfErr}, 32'hF);
    end

    // Seeded random mix
    for (int it = 0; it < 24; it++) begin
      int bits;
      bit lsb;
      case ($urandom % 3)
        0: bits = 4 << ($urandom % 4);
        default: bits = 4 + int'($urandom % 29);
      endcase
      lsb = 1'($urandom % 2);
      runTx(bits, lsb, 1 + int'($urandom % 4), 32'd0, 1'b0);
      runRx(bits, lsb, 1 + int'($urandom % (mLanes(bits) * 3)));
    end

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChk++;
      nBad++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("  test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end
endmodule